// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Loader

This block is the write-only programming port of a frequency synthesizer. A host shifts 24-bit words over a three-wire bus: a serial clock, a data line and a load strobe. When the load strobe rises, the block sends the completed word to one of three holding latches. The two lowest bits of the word pick the latch: control, reference divider or feedback divider. The rest of the synthesizer reads the parallel latch contents directly. Each latch also gives a one-cycle update strobe.

All three bus lines are sampled in the system clock domain through two-flop synchronizers. Edges are detected after synchronization. A load with the wrong number of shifted bits is dropped and flagged. The block also watches the start-up programming order, which is reference, then control, then feedback. It raises a ready flag once that order has been completed and pulses an error on any write that breaks it.

The serial bus cannot be stalled, so there is no back-pressure anywhere. The latch contents are plain level outputs and the strobes are plain single-cycle pulses.

Top module: `tw_reg_loader`

## Requirements
- R1: While reset is asserted and directly after it, all three latch outputs read zero, `init_done` is low and no strobe or error pulse is active.
- R2: Data is taken on each rising edge of `ser_clk`, most significant bit first. A 24-bit word lands whole in the latch chosen by its bits [1:0]: 2'b00 selects control (`ctrl_word`), 2'b01 selects reference (`ref_word`) and 2'b10 selects feedback (`fdiv_word`).
- R3: A latch and its update strobe change only in response to a rising `ser_le`. The change happens on the fourth rising `clk` edge after the input rises, and the strobe stays high for exactly one cycle.
- R4: A 24-bit word whose bits [1:0] are 2'b11 changes no latch, gives no strobe and does not affect the start-up order tracking.
- R5: If `ser_le` rises after any bit count other than 24, `frame_err` pulses for one cycle on the third `clk` edge after the rise. The word changes no latch and does not affect order tracking.
- R6: `init_done` goes high together with the feedback strobe of the write that completes the order reference, control, feedback.
- R7: Before `init_done`, a valid-address write other than the expected one still updates its latch and pulses `seq_err` in the same cycle. Tracking then restarts: after an out-of-order reference write, control is expected next; after any other out-of-order write, reference is expected next.
- R8: Once `init_done` is high, it stays high until reset, and no later write pulses `seq_err`.
- R9: `ser_clk` may pause for any time between bytes while `ser_le` stays low, and the bits still assemble into one word.
- R10: At most one of the three update strobes and `frame_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to `clk` |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; its rising edge commits the word |
| ctrl_word | output | 24 | Control latch contents |
| ref_word | output | 24 | Reference-divider latch contents |
| fdiv_word | output | 24 | Feedback-divider latch contents |
| ctrl_upd | output | 1 | One-cycle strobe when the control latch is written |
| ref_upd | output | 1 | One-cycle strobe when the reference latch is written |
| fdiv_upd | output | 1 | One-cycle strobe when the feedback latch is written |
| init_done | output | 1 | Start-up write order has been completed |
| seq_err | output | 1 | One-cycle pulse on an out-of-order start-up write |
| frame_err | output | 1 | One-cycle pulse when a load had a bit count other than 24 |

## Verification
The properties assume that each serial line is held stable for several system clocks around every transition. This means `ser_dat` is settled before `ser_clk` rises, and `ser_le` never moves in the same synchronized cycle as `ser_clk`. The stimulus holds every serial phase for three system clocks, so both synchronized lines always see consistent data. A behavioural model in the bench works out the expected latch values, strobes and order state from the words it sends. It applies each effect at the fixed latency after the load edge and compares every output on every clock.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Latch address carried in bits [1:0] of every word
  typedef enum logic [1:0] {
    DST_CTRL = 2'b00,
    DST_REF  = 2'b01,
    DST_FDIV = 2'b10,
    DST_RSVD = 2'b11
  } tw_dest_e;

  // Progress through the start-up write order
  typedef enum logic [1:0] {
    SQ_WREF,
    SQ_WCTRL,
    SQ_WFDIV,
    SQ_DONE
  } tw_seq_e;

  localparam int unsigned NUM_LATCH = 3;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sle_s,
  output logic              commit,
  output logic [WORD_W-1:0] word,
  output logic              frame_err
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              sclk_q, sle_q;
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              sclk_rise, le_rise;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign le_rise   = sle_s & ~sle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      sle_q     <= 1'b0;
      sr        <= '0;
      cnt       <= '0;
      commit    <= 1'b0;
      word      <= '0;
      frame_err <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      sle_q     <= sle_s;
      commit    <= 1'b0;
      frame_err <= 1'b0;
      if (le_rise) begin
        cnt <= '0;
        if (cnt == FULL) begin
          commit <= 1'b1;
          word   <= sr;
        end else begin
          frame_err <= 1'b1;
        end
      end else if (sclk_rise) begin
        sr <= {sr[WORD_W-2:0], sdat_s};
        // saturate one past full so long frames never wrap to a legal count
        if (cnt <= FULL) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tw_latch_bank.sv
module tw_latch_bank
  import tw_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             commit,
  input  logic [WORD_W-1:0]                word,
  output logic [NUM_LATCH-1:0][WORD_W-1:0] latches,
  output logic [NUM_LATCH-1:0]             upd
);
  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
    logic hit;
    assign hit = commit && (word[1:0] == 2'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latches[i] <= '0;
        upd[i]     <= 1'b0;
      end else begin
        upd[i] <= hit;
        if (hit) latches[i] <= word;
      end
    end
  end
endmodule

// File: rtl/tw_seq_track.sv
module tw_seq_track
  import tw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [1:0] addr,
  output logic       init_done,
  output logic       seq_err
);
  tw_seq_e  st;
  tw_dest_e want, got;

  assign got = tw_dest_e'(addr);

  always_comb begin
    unique case (st)
      SQ_WREF:  want = DST_REF;
      SQ_WCTRL: want = DST_CTRL;
      default:  want = DST_FDIV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_WREF;
      seq_err <= 1'b0;
    end else begin
      seq_err <= 1'b0;
      if (commit && got != DST_RSVD && st != SQ_DONE) begin
        if (got == want) begin
          unique case (st)
            SQ_WREF:  st <= SQ_WCTRL;
            SQ_WCTRL: st <= SQ_WFDIV;
            default:  st <= SQ_DONE;
          endcase
        end else begin
          seq_err <= 1'b1;
          st      <= (got == DST_REF) ? SQ_WCTRL : SQ_WREF;
        end
      end
    end
  end

  assign init_done = (st == SQ_DONE);
endmodule

// File: rtl/tw_reg_loader.sv
module tw_reg_loader
  import tw_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] ref_word,
  output logic [WORD_W-1:0] fdiv_word,
  output logic              ctrl_upd,
  output logic              ref_upd,
  output logic              fdiv_upd,
  output logic              init_done,
  output logic              seq_err,
  output logic              frame_err
);
  logic [2:0]                       raw_s;
  logic                             commit;
  logic [WORD_W-1:0]                word;
  logic [NUM_LATCH-1:0][WORD_W-1:0] latches;
  logic [NUM_LATCH-1:0]             upd;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_le, ser_dat, ser_clk}), .q(raw_s)
  );

  tw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(raw_s[0]), .sdat_s(raw_s[1]), .sle_s(raw_s[2]),
    .commit(commit), .word(word), .frame_err(frame_err)
  );

  tw_latch_bank #(.WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
    .latches(latches), .upd(upd)
  );

  tw_seq_track u_seq (
    .clk(clk), .rst_n(rst_n), .commit(commit), .addr(word[1:0]),
    .init_done(init_done), .seq_err(seq_err)
  );

  assign ctrl_word = latches[DST_CTRL];
  assign ref_word  = latches[DST_REF];
  assign fdiv_word = latches[DST_FDIV];
  assign ctrl_upd  = upd[DST_CTRL];
  assign ref_upd   = upd[DST_REF];
  assign fdiv_upd  = upd[DST_FDIV];
endmodule

// File: rtl/tw_loader_chk.sv
module tw_loader_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] ctrl_word,
  input logic [WORD_W-1:0] ref_word,
  input logic [WORD_W-1:0] fdiv_word,
  input logic              ctrl_upd,
  input logic              ref_upd,
  input logic              fdiv_upd,
  input logic              init_done,
  input logic              seq_err,
  input logic              frame_err
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_upd, ref_upd, fdiv_upd, frame_err}));

  // R2
  ctrl_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_upd |-> ctrl_word[1:0] == 2'b00);
  // R2
  ref_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |-> ref_word[1:0] == 2'b01);
  // R2
  fdiv_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fdiv_upd |-> fdiv_word[1:0] == 2'b10);

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_upd |-> $stable(ctrl_word));
  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_upd |-> $stable(ref_word));
  // R3
  fdiv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fdiv_upd |-> $stable(fdiv_word));

  // R5
  frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !(ctrl_upd || ref_upd || fdiv_upd));

  // R6
  init_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> fdiv_upd);

  // R8
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R8
  no_err_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !seq_err);
endmodule

bind tw_reg_loader tw_loader_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ctrl_word(ctrl_word), .ref_word(ref_word), .fdiv_word(fdiv_word),
  .ctrl_upd(ctrl_upd), .ref_upd(ref_upd), .fdiv_upd(fdiv_upd),
  .init_done(init_done), .seq_err(seq_err), .frame_err(frame_err)
);

// File: tb/tb_tw_reg_loader.sv
`timescale 1ns/1ps
module tb_tw_reg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [23:0] ctrl_word, ref_word, fdiv_word;
  logic ctrl_upd, ref_upd, fdiv_upd, init_done, seq_err, frame_err;

  always #2 clk = ~clk;  // 250 MHz

  tw_reg_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ctrl_word(ctrl_word), .ref_word(ref_word), .fdiv_word(fdiv_word),
    .ctrl_upd(ctrl_upd), .ref_upd(ref_upd), .fdiv_upd(fdiv_upd),
    .init_done(init_done), .seq_err(seq_err), .frame_err(frame_err)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [23:0] m_word [3];
  logic        m_upd  [3];
  int          m_stage = 0;   // 0 want ref, 1 want ctrl, 2 want fdiv, 3 done
  logic        m_seq = 1'b0, m_ferr = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial for (int i = 0; i < 3; i++) begin m_word[i] = '0; m_upd[i] = 1'b0; end

  // per-clock comparison with the model
  always begin
    @(posedge clk);
    #1;
    chk(ctrl_word == m_word[0], "R2", "ctrl_word", 32'(ctrl_word), 32'(m_word[0]));
    chk(ref_word  == m_word[1], "R2", "ref_word",  32'(ref_word),  32'(m_word[1]));
    chk(fdiv_word == m_word[2], "R2", "fdiv_word", 32'(fdiv_word), 32'(m_word[2]));
    chk({ctrl_upd, ref_upd, fdiv_upd} == {m_upd[0], m_upd[1], m_upd[2]}, "R3", "strobes",
        32'({ctrl_upd, ref_upd, fdiv_upd}), 32'({m_upd[0], m_upd[1], m_upd[2]}));
    chk(init_done == (m_stage == 3), "R6", "init_done", 32'(init_done), 32'(m_stage == 3));
    chk(seq_err == m_seq, "R7", "seq_err", 32'(seq_err), 32'(m_seq));
    chk(frame_err == m_ferr, "R5", "frame_err", 32'(frame_err), 32'(m_ferr));
    chk($countones({ctrl_upd, ref_upd, fdiv_upd, frame_err}) <= 1, "R10", "pulse overlap",
        32'({ctrl_upd, ref_upd, fdiv_upd, frame_err}), 32'd0);
    for (int i = 0; i < 3; i++) m_upd[i] = 1'b0;
    m_seq  = 1'b0;
    m_ferr = 1'b0;
  end

  task automatic model_apply(input logic [23:0] w);
    int a, want;
    a = int'(w[1:0]);
    if (a == 3) return;
    m_word[a] = w;
    m_upd[a]  = 1'b1;
    if (m_stage != 3) begin
      want = (m_stage == 0) ? 1 : (m_stage == 1) ? 0 : 2;
      if (a == want) m_stage++;
      else begin
        m_seq   = 1'b1;
        m_stage = (a == 1) ? 1 : 0;
      end
    end
  endtask

  // shift n bits MSB first; optional long pause after every byte
  task automatic send(input logic [31:0] bits, input int n, input bit byte_gaps);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) ser_dat = bits[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      if (byte_gaps && (i % 8 == 0) && i != 0) repeat (25) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    ser_le = 1'b1;
    repeat (3) @(posedge clk);
    if (n != 24) m_ferr = 1'b1;
    @(posedge clk);
    if (n == 24) model_apply(bits[23:0]);
    repeat (3) @(negedge clk);
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    // R1: reset state
    chk(ctrl_word == 0 && ref_word == 0 && fdiv_word == 0, "R1", "latches in reset",
        32'(ctrl_word | ref_word | fdiv_word), 0);
    chk(!init_done && !seq_err && !frame_err, "R1", "flags in reset",
        32'({init_done, seq_err, frame_err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ctrl_upd && !ref_upd && !fdiv_upd && !init_done, "R1", "after reset",
        32'({ctrl_upd, ref_upd, fdiv_upd, init_done}), 0);

    send(32'h81F0E4, 24, 1'b0);   // R7: control first, out of order
    send(32'h3C5A71, 24, 1'b0);   // reference, now expecting control
    send(32'h5AA5B6, 24, 1'b0);   // R7: feedback too early
    send(32'h123457, 23, 1'b0);   // R5: short frame
    send(32'h1ABCDE1, 25, 1'b0);  // R5: long frame
    send(32'hC3C3C7, 24, 1'b0);   // R4: reserved address
    chk(ctrl_word == 24'h81F0E4 && ref_word == 24'h3C5A71 && fdiv_word == 24'h5AA5B6,
        "R4", "latches after reserved", 32'(ctrl_word ^ ref_word ^ fdiv_word),
        32'(24'h81F0E4 ^ 24'h3C5A71 ^ 24'h5AA5B6));
    chk(!init_done, "R4", "order untouched by reserved", 32'(init_done), 0);

    send(32'h0F1E2D, 24, 1'b0);   // reference (low bits 01)
    send(32'h6B7C88, 24, 1'b1);   // R9: control with byte pauses
    chk(ctrl_word == 24'h6B7C88, "R9", "gapped word", 32'(ctrl_word), 32'h6B7C88);
    send(32'h24680A, 24, 1'b0);   // feedback completes order
    chk(init_done, "R6", "init after order", 32'(init_done), 1);

    send(32'h0F0F0C, 24, 1'b0);   // R8: control again after init
    send(32'h777775, 24, 1'b0);   // R8: reference again after init
    chk(init_done, "R8", "init stays high", 32'(init_done), 1);

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule